// File: doc/BRIEF.md
# Sampling Converter Control Logic

This block is the digital sequencer of a 12-bit sampling converter with a parallel result bus. A host selects the converter with an active-low select, asks for a conversion with an active-low begin strobe and reads the bus with an active-low fetch strobe. The analog front end is stood in for by the `smp_in` port, which is captured on the cycle a conversion is accepted. A down-counter plays the part of the conversion time. While the conversion runs, `run_n` is held low. When the count expires, the captured word becomes the new result and `run_n` returns high.

The bus is modelled with a per-bit output enable in place of real tri-state drivers. When the begin and fetch strobes are wired to one common host strobe, a single low-going strobe does two things: it launches conversion N+1 and it shows result N on the bus. Result N+1 takes its place at completion. A sleep request parks the converter. On release, a wake-up interval set in nanoseconds and turned into clock cycles by parameters must run out before a new start is taken.

All four control inputs pass through a two-flop synchroniser before use. A start is a falling edge of the synchronised begin strobe, so a strobe held low fires only once.

Top module: `sconv_ctrl`

## Requirements
- R1: A falling edge of `begin_n` while `sel_n` is low starts a conversion, provided the block is idle. `smp_in` is captured on the accepting edge, which is the third rising clock edge after the input falls. `run_n` is low from that edge on.
- R2: A falling edge of `begin_n` while `sel_n` is high starts nothing. `run_n` stays high and `q_out` keeps its value.
- R3: `run_n` stays low for exactly CONV_CYC clock cycles per conversion (default 16).
- R4: A start edge that arrives while a conversion runs is ignored. The running conversion is not restarted and its captured sample is kept.
- R5: `q_out` holds the previous result for the whole conversion. It takes the newly captured sample on the same clock edge where `run_n` returns high.
- R6: `q_out_oe` is all ones (bit i enables bit i of `q_out`) when both `sel_n` and `fetch_n` are low, with two cycles of synchroniser delay. Otherwise it is all zeros.
- R7: When `begin_n` and `fetch_n` are driven by one strobe, pulling it low enables the bus with the previous result and starts a new conversion. The new result appears when `run_n` rises.
- R8: While `sleep_req` is high, no conversion is started. A conversion already running completes normally first.
- R9: After `sleep_req` falls, start edges are dropped, not queued, for WAKE_CYC cycles. WAKE_CYC is ceil(WAKE_NS*1000/CLK_PS), 70 at defaults. Start edges after that interval are accepted.
- R10: After reset, `q_out` is zero, `run_n` is high and `q_out_oe` is zero.
- R11: A `begin_n` held low starts one conversion only. A later start needs a new high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low converter select |
| begin_n | input | 1 | Active-low conversion request |
| fetch_n | input | 1 | Active-low bus read strobe |
| sleep_req | input | 1 | High parks the converter |
| smp_in | input | 12 | Sample word standing in for the analog input |
| run_n | output | 1 | Low while a conversion is in progress |
| q_out | output | 12 | Latest conversion result |
| q_out_oe | output | 12 | Per-bit output enable for q_out |

## Verification
The due cycle of each result follows from the input path. `run_n` falls on the third rising edge after `begin_n` falls: two synchroniser flops, then the accepting edge. It rises CONV_CYC edges later, on the same edge where `q_out` takes the new sample. `q_out_oe` follows `sel_n` and `fetch_n` after two edges. The wake-up window closes WAKE_CYC edges after the synchronised release of `sleep_req`. The bench drives inputs on the falling edge. It steps a behavioural model through the same two-stage input delay on each rising edge and compares all outputs on every falling edge. Directed checks sample `run_n` one cycle before and exactly at its due edge, and read `q_out` after each scenario has settled.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SLEEP = 2'd2,
      ST_WAKE  = 2'd3
   } sconv_st_e;

   function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sconv_sync.sv
module sconv_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sconv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[i] <= RST_VAL;
            end else begin
               if (i == 0) stg[i] <= d;
               else        stg[i] <= stg[(i == 0) ? 0 : i - 1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sconv_seq.sv
module sconv_seq
   import sconv_pkg::*;
#(
   parameter int unsigned DW       = 12,
   parameter int unsigned CONV_CYC = 16,
   parameter int unsigned WAKE_CYC = 70,
   localparam int unsigned CNT_W   = $clog2(umax(CONV_CYC, WAKE_CYC) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall_evt,
   input  logic          sleep_s,
   input  logic [DW-1:0] smp_in,
   output logic          run_n,
   output logic          load,
   output logic [DW-1:0] cap
);
   generate
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("sconv_seq: CONV_CYC must be at least 1");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("sconv_seq: WAKE_CYC must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);
   localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);

   sconv_st_e        st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
         cap <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (sleep_s) begin
                  st <= ST_SLEEP;
               end else if (fall_evt) begin
                  st  <= ST_CONV;
                  cnt <= CONV_LD;
                  cap <= smp_in;
               end
            end
            ST_CONV: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            ST_SLEEP: begin
               if (!sleep_s) begin
                  st  <= ST_WAKE;
                  cnt <= WAKE_LD;
               end
            end
            ST_WAKE: begin
               if (sleep_s)         st <= ST_SLEEP;
               else if (cnt == '0)  st <= ST_IDLE;
               else                 cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign run_n = (st != ST_CONV);
   assign load  = (st == ST_CONV) && (cnt == '0);

   // R4: a running conversion counts down without reload
   a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CONV && cnt != '0) |=> (st == ST_CONV && cnt == $past(cnt) - 1'b1));
   // R8: no conversion leaves the sleep state directly
   a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP) |=> (st != ST_CONV));
   // R9: wake-up window drops starts
   a_r9_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAKE) |=> (st != ST_CONV));
   // R1: a conversion only begins after a qualified start edge
   a_r1_start_source: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_n) |-> $past(fall_evt));
endmodule

// File: rtl/sconv_outbuf.sv
module sconv_outbuf #(
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] cap_i,
   input  logic          sel_s,
   input  logic          fetch_s,
   output logic [DW-1:0] q_out,
   output logic [DW-1:0] q_out_oe
);
   logic [DW-1:0] result;
   logic          bus_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    result <= '0;
      else if (load) result <= cap_i;
   end

   assign bus_en = ~sel_s & ~fetch_s;

   generate
      for (genvar b = 0; b < DW; b++) begin : g_oe
         assign q_out_oe[b] = bus_en;
      end
   endgenerate

   assign q_out = result;

   // R5: result takes the captured sample at completion
   a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q_out == $past(cap_i)));
   // R5: result holds between completions
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q_out));
endmodule

// File: rtl/sconv_ctrl.sv
module sconv_ctrl
   import sconv_pkg::*;
#(
   parameter int unsigned DW       = 12,
   parameter int unsigned CONV_CYC = 16,
   parameter int unsigned CLK_PS   = 5000,
   parameter int unsigned WAKE_NS  = 350,
   parameter int unsigned SYNC_STG = 2,
   localparam int unsigned WAKE_CYC = cdiv(WAKE_NS * 1000, CLK_PS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          begin_n,
   input  logic          fetch_n,
   input  logic          sleep_req,
   input  logic [DW-1:0] smp_in,
   output logic          run_n,
   output logic [DW-1:0] q_out,
   output logic [DW-1:0] q_out_oe
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("sconv_ctrl: DW must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("sconv_ctrl: CLK_PS must be positive");
      end
   endgenerate

   logic [3:0] raw, syn;
   logic       sel_s, begin_s, fetch_s, sleep_s;
   logic       begin_d, fall_evt, load;
   logic [DW-1:0] cap;

   assign raw = {sleep_req, fetch_n, begin_n, sel_n};

   sconv_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b0111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   assign sel_s   = syn[0];
   assign begin_s = syn[1];
   assign fetch_s = syn[2];
   assign sleep_s = syn[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin_d <= 1'b1;
      else        begin_d <= begin_s;
   end

   assign fall_evt = begin_d & ~begin_s & ~sel_s;

   sconv_seq #(.DW(DW), .CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .sleep_s(sleep_s),
      .smp_in(smp_in), .run_n(run_n), .load(load), .cap(cap)
   );

   sconv_outbuf #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .load(load), .cap_i(cap),
      .sel_s(sel_s), .fetch_s(fetch_s), .q_out(q_out), .q_out_oe(q_out_oe)
   );

   // R11: a start edge needs a high level on the previous cycle
   a_r11_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !fall_evt);
endmodule

// File: tb/sconv_ctrl_tb.sv
module sconv_ctrl_tb_top;
   localparam int CONV = 16;
   localparam int WAKE = 70;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, begin_n = 1'b1, fetch_n = 1'b1, sleep_req = 1'b0;
   logic [11:0] smp_in = '0;
   logic run_n;
   logic [11:0] q_out, q_out_oe;

   int checks = 0, errors = 0, cyc = 0;
   bit tie = 1'b0;

   always #2.5 clk = ~clk;

   sconv_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .begin_n(begin_n),
      .fetch_n(tie ? begin_n : fetch_n), .sleep_req(sleep_req),
      .smp_in(smp_in), .run_n(run_n), .q_out(q_out), .q_out_oe(q_out_oe)
   );

   // behavioural model: 0 idle, 1 converting, 2 asleep, 3 waking
   int  m_mode = 0, m_cnt = 0;
   bit  m_s1[4], m_s2[4];
   bit  m_bd = 1;
   logic [11:0] m_cap = '0, m_res = '0;

   always @(posedge clk) begin
      bit fall;
      bit in_now[4];
      in_now[0] = sel_n; in_now[1] = begin_n;
      in_now[2] = tie ? begin_n : fetch_n; in_now[3] = sleep_req;
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_cap = '0; m_res = '0; m_bd = 1;
         for (int i = 0; i < 4; i++) begin
            m_s1[i] = (i != 3); m_s2[i] = (i != 3);
         end
      end else begin
         fall = m_bd && !m_s2[1] && !m_s2[0];
         case (m_mode)
            0: if (m_s2[3]) m_mode = 2;
               else if (fall) begin m_mode = 1; m_cnt = CONV - 1; m_cap = smp_in; end
            1: if (m_cnt == 0) begin m_res = m_cap; m_mode = 0; end
               else m_cnt--;
            2: if (!m_s2[3]) begin m_mode = 3; m_cnt = WAKE - 1; end
            default: if (m_s2[3]) m_mode = 2;
               else if (m_cnt == 0) m_mode = 0;
               else m_cnt--;
         endcase
         m_bd = m_s2[1];
         for (int i = 0; i < 4; i++) begin
            m_s2[i] = m_s1[i]; m_s1[i] = in_now[i];
         end
      end
   end

   task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h at cycle %0d", tag, got, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check("R3 run_n", {11'd0, run_n}, {11'd0, m_mode != 1});
         check("R5 q_out", q_out, m_res);
         check("R6 q_out_oe", q_out_oe, (!m_s2[0] && !m_s2[2]) ? 12'hFFF : 12'h000);
      end
      if (cyc > 200000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_begin(int width);
      begin_n = 1'b0; wait_cyc(width); begin_n = 1'b1;
   endtask

   initial begin
      wait_cyc(3);
      check("R10 q_out", q_out, 12'h000);
      check("R10 run_n", {11'd0, run_n}, 12'h001);
      check("R10 q_out_oe", q_out_oe, 12'h000);
      rst_n = 1'b1;
      wait_cyc(3);

      // R1 / R6: select and fetch low, result latched at end
      sel_n = 0; fetch_n = 0; smp_in = 12'hA5C;
      wait_cyc(3);
      check("R6 oe on", q_out_oe, 12'hFFF);
      begin_n = 1'b0;
      wait_cyc(2);
      check("R1 run_n before accept", {11'd0, run_n}, 12'h001);
      wait_cyc(1);
      check("R1 run_n at accept", {11'd0, run_n}, 12'h000);
      begin_n = 1'b1; smp_in = 12'h111;
      wait_cyc(CONV - 1);
      check("R3 still busy last cycle", {11'd0, run_n}, 12'h000);
      check("R5 previous held", q_out, 12'h000);
      wait_cyc(1);
      check("R3 busy released", {11'd0, run_n}, 12'h001);
      check("R1 captured sample", q_out, 12'hA5C);

      // R4: second start during conversion ignored
      smp_in = 12'h3C3; pulse_begin(2);
      wait_cyc(6); smp_in = 12'h777; pulse_begin(2);
      wait_cyc(CONV + 10);
      check("R4 first sample kept", q_out, 12'h3C3);

      // R2: deselected start ignored
      sel_n = 1; smp_in = 12'h0F0; wait_cyc(2); pulse_begin(2);
      wait_cyc(CONV + 6);
      check("R2 no conversion", q_out, 12'h3C3);
      check("R6 oe off when deselected", q_out_oe, 12'h000);
      sel_n = 0; fetch_n = 1; wait_cyc(3);
      check("R6 oe off when fetch high", q_out_oe, 12'h000);

      // R11: held-low strobe converts once
      smp_in = 12'h456; begin_n = 0; wait_cyc(4); smp_in = 12'h999;
      wait_cyc(CONV + 20);
      check("R11 single conversion", q_out, 12'h456);
      check("R11 not running", {11'd0, run_n}, 12'h001);
      begin_n = 1; wait_cyc(3);

      // R7: tied strobe
      tie = 1; smp_in = 12'hBEE; begin_n = 0; wait_cyc(4);
      check("R7 previous on bus", q_out, 12'h456);
      check("R7 bus enabled", q_out_oe, 12'hFFF);
      wait_cyc(CONV + 2);
      check("R7 new result", q_out, 12'hBEE);
      begin_n = 1; wait_cyc(3); tie = 0;

      // R8: sleep blocks starts; running conversion completes
      smp_in = 12'hC01; pulse_begin(1); wait_cyc(3);
      sleep_req = 1; wait_cyc(CONV + 4);
      check("R8 running conversion finished", q_out, 12'hC01);
      smp_in = 12'h222; pulse_begin(2); wait_cyc(CONV + 4);
      check("R8 start while asleep dropped", q_out, 12'hC01);
      check("R8 idle while asleep", {11'd0, run_n}, 12'h001);

      // R9: wake window drops starts, then accepts
      sleep_req = 0; wait_cyc(10);
      smp_in = 12'h333; pulse_begin(2); wait_cyc(CONV + 4);
      check("R9 start in wake window dropped", q_out, 12'hC01);
      wait_cyc(WAKE);
      smp_in = 12'h5A5; pulse_begin(2); wait_cyc(CONV + 6);
      check("R9 start after wake accepted", q_out, 12'h5A5);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule